// File: doc/BRIEF.md
# Ring Oscillator Edge Counter Bank with Serial Readout

The block measures the frequencies of a set of ring oscillators arranged as stressed/reference pairs. Every oscillator output clocks a private counter. A shared measurement window input, `meas_en`, decides when these counters run. Each counter resynchronises the window into its own oscillator domain. It clears when a new window opens and counts oscillator rising edges while the window stays open. When the window closes, the counter freezes.

Once every counter is quiet, a capture strobe in the scan clock domain copies all counts at once into one wide shift register. The register is then read one bit per scan clock cycle through a single serial output. The two counts of a pair sit next to each other in the stream, so a host can compare the aged oscillator with its fresh partner by difference.

Top module: `ro_count_bank`

## Requirements
- R1: The bank has `2*NUM_PAIRS` oscillator inputs, and each input has its own counter. Input `osc_in[2p]` is the stressed oscillator of pair p and `osc_in[2p+1]` is its reference.
- R2: While `meas_en` is high, a counter advances by one on every rising edge of its own oscillator. The count left after a window equals the number of oscillator rising edges that fall inside the window, within ±1.
- R3: A counter returns to zero when a new window opens, so the counts from a later window replace those of an earlier one.
- R4: While `meas_en` is low, a counter holds its value. Capturing again with no new window yields the same counts.
- R5: A counter that reaches `2**COUNT_W-1` stays at that value until the next window opens.
- R6: `cap_stb` high at a `scan_clk` rising edge loads every count into the shift register in that single edge. Capture takes priority over `shift_en`.
- R7: After a capture, `sdo` presents the count of input 0 first, then the counts of inputs 1, 2 and onward, each most significant bit first. Each `scan_clk` edge with `shift_en` high (and `cap_stb` low) advances the stream by one bit.
- R8: Zeros enter at the tail of the shift register, so `sdo` reads 0 once all `2*NUM_PAIRS*COUNT_W` bits have left.
- R9: With both `cap_stb` and `shift_en` low, the shift register and `sdo` hold their values.
- R10: Synchronous active-high `rst` clears the shift register and `sdo` at a `scan_clk` edge. It clears each counter at an edge of that counter's oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan clock for capture and serial shift |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 2*NUM_PAIRS | Oscillator outputs, stressed at even index, reference at odd index |
| meas_en | input | 1 | Measurement window; counters run while high |
| cap_stb | input | 1 | Parallel load of all counts into the shift register |
| shift_en | input | 1 | Advance the serial stream by one bit |
| sdo | output | 1 | Registered serial data out, first bit of the stream on top |

## Verification
The bench instantiates five pairs with `COUNT_W` set to 10 instead of 16. A 7 µs window on the fastest oscillator therefore runs past 1023, which puts saturation (R5) within reach in a short run. The ten oscillators run at ten distinct even periods from 6 ns to 24 ns. A mix-up in stream order or a lost pair shows up as a count in the wrong slot. The narrower words also keep each read-out short enough to cover the paused shift, the tail zeros, and a capture that collides with a shift.

// File: rtl/ro_scan_pkg.sv
package ro_scan_pkg;

  localparam int DEF_PAIRS   = 5;
  localparam int DEF_COUNT_W = 16;

  // Highest chain bit holding the count of oscillator idx; oscillator 0 leaves first.
  function automatic int slot_msb(input int idx, input int width, input int n_osc);
    return n_osc * width - 1 - idx * width;
  endfunction

endpackage

// File: rtl/ro_en_sync.sv
module ro_en_sync (
  input  logic osc_clk,
  input  logic rst,
  input  logic meas_en,
  output logic win_open,
  output logic win_start
);

  logic [2:0] pipe_q;

  always_ff @(posedge osc_clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[1:0], meas_en};
  end

  // Stages 0 and 1 settle metastability; stage 2 is the resolved window.
  assign win_open  = pipe_q[2];
  assign win_start = pipe_q[1] & ~pipe_q[2];

endmodule

// File: rtl/ro_edge_counter.sv
module ro_edge_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               osc_clk,
  input  logic               rst,
  input  logic               meas_en,
  output logic [COUNT_W-1:0] count
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic win_open, win_start;

  ro_en_sync u_sync (
    .osc_clk  (osc_clk),
    .rst      (rst),
    .meas_en  (meas_en),
    .win_open (win_open),
    .win_start(win_start)
  );

  always_ff @(posedge osc_clk) begin
    if (rst)                               count <= '0;
    else if (win_start)                    count <= '0;
    else if (win_open && count != CNT_MAX) count <= count + 1'b1;
  end

  p_clear_r3: assert property (@(posedge osc_clk) disable iff (rst)
    win_start |=> count == '0);

  p_step_r2: assert property (@(posedge osc_clk) disable iff (rst)
    (win_open && !win_start && count != CNT_MAX) |=> count == $past(count) + 1'b1);

  p_hold_r4: assert property (@(posedge osc_clk) disable iff (rst)
    (!win_open && !win_start) |=> $stable(count));

  p_sat_r5: assert property (@(posedge osc_clk) disable iff (rst)
    (count == CNT_MAX && !win_start) |=> count == CNT_MAX);

endmodule

// File: rtl/ro_scan_chain.sv
module ro_scan_chain #(
  parameter int CHAIN_W = 160
) (
  input  logic               scan_clk,
  input  logic               rst,
  input  logic               cap_stb,
  input  logic               shift_en,
  input  logic [CHAIN_W-1:0] par_in,
  output logic               sdo
);

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge scan_clk) begin
    if (rst)           chain_q <= '0;
    else if (cap_stb)  chain_q <= par_in;
    else if (shift_en) chain_q <= {chain_q[CHAIN_W-2:0], 1'b0};
  end

  assign sdo = chain_q[CHAIN_W-1];

  p_load_r6: assert property (@(posedge scan_clk) disable iff (rst)
    cap_stb |=> chain_q == $past(par_in));

  p_shift_r7: assert property (@(posedge scan_clk) disable iff (rst)
    (shift_en && !cap_stb) |=> chain_q[CHAIN_W-1:1] == $past(chain_q[CHAIN_W-2:0]));

  p_fill_r8: assert property (@(posedge scan_clk) disable iff (rst)
    (shift_en && !cap_stb) |=> !chain_q[0]);

  p_hold_r9: assert property (@(posedge scan_clk) disable iff (rst)
    (!shift_en && !cap_stb) |=> $stable(chain_q));

  p_reset_r10: assert property (@(posedge scan_clk)
    rst |=> !sdo);

endmodule

// File: rtl/ro_count_bank.sv
module ro_count_bank #(
  parameter int NUM_PAIRS = ro_scan_pkg::DEF_PAIRS,
  parameter int COUNT_W   = ro_scan_pkg::DEF_COUNT_W
) (
  input  logic                   scan_clk,
  input  logic                   rst,
  input  logic [2*NUM_PAIRS-1:0] osc_in,
  input  logic                   meas_en,
  input  logic                   cap_stb,
  input  logic                   shift_en,
  output logic                   sdo
);

  localparam int NUM_OSC = 2 * NUM_PAIRS;
  localparam int CHAIN_W = NUM_OSC * COUNT_W;

  logic [CHAIN_W-1:0] counts_flat;

  for (genvar gi = 0; gi < NUM_OSC; gi++) begin : g_osc
    localparam int MSB = ro_scan_pkg::slot_msb(gi, COUNT_W, NUM_OSC);
    logic [COUNT_W-1:0] cnt;

    ro_edge_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .osc_clk(osc_in[gi]),
      .rst    (rst),
      .meas_en(meas_en),
      .count  (cnt)
    );

    assign counts_flat[MSB -: COUNT_W] = cnt;
  end

  ro_scan_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .scan_clk(scan_clk),
    .rst     (rst),
    .cap_stb (cap_stb),
    .shift_en(shift_en),
    .par_in  (counts_flat),
    .sdo     (sdo)
  );

endmodule

// File: tb/sim_ro_count_bank.sv
`timescale 1ns/1ps
module sim_ro_count_bank;

  localparam int NP   = 5;
  localparam int CW   = 10;
  localparam int NOSC = 2 * NP;
  localparam int MAXC = (1 << CW) - 1;

  logic            scan_clk = 1'b0;
  logic            rst = 1'b1;
  logic [NOSC-1:0] osc;
  logic            meas_en = 1'b0;
  logic            cap_stb = 1'b0;
  logic            shift_en = 1'b0;
  logic            sdo;

  int n_vec = 0;
  int n_bad = 0;
  int words  [NOSC];
  int first_w[NOSC];

  always #2.5 scan_clk = ~scan_clk;

  // Oscillator i runs at period 6+2i ns.
  for (genvar gi = 0; gi < NOSC; gi++) begin : g_ro
    logic o = 1'b0;
    always #(3 + gi) o = ~o;
    assign osc[gi] = o;
  end

  ro_count_bank #(.NUM_PAIRS(NP), .COUNT_W(CW)) u0 (
    .scan_clk(scan_clk), .rst(rst), .osc_in(osc), .meas_en(meas_en),
    .cap_stb(cap_stb), .shift_en(shift_en), .sdo(sdo)
  );

  function automatic int period_of(input int i);
    return 6 + 2 * i;
  endfunction

  task automatic check(input string req, input int got, input int exp, input int tol);
    int d;
    n_vec++;
    d = got - exp;
    if (d < -tol || d > tol) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (tol %0d)", req, got, exp, tol);
    end
  endtask

  task automatic capture(input logic with_shift);
    @(negedge scan_clk);
    cap_stb  = 1'b1;
    shift_en = with_shift;
    @(negedge scan_clk);
    cap_stb  = 1'b0;
    shift_en = 1'b0;
  endtask

  // Reads all words, MSB first, oscillator 0 first; then checks tail zeros.
  task automatic read_all(input logic do_pause);
    logic held;
    for (int w = 0; w < NOSC; w++) words[w] = 0;
    for (int b = 0; b < NOSC * CW; b++) begin
      if (do_pause && b == 23) begin
        held = sdo;
        for (int k = 0; k < 3; k++) begin
          @(negedge scan_clk);
          check("R9 sdo held while idle", int'(sdo), int'(held), 0);
        end
      end
      words[b / CW] = (words[b / CW] << 1) | int'(sdo);
      shift_en = 1'b1;
      @(negedge scan_clk);
      shift_en = 1'b0;
    end
    for (int t = 0; t < 4; t++) begin
      check("R8 tail bit zero", int'(sdo), 0, 0);
      shift_en = 1'b1;
      @(negedge scan_clk);
      shift_en = 1'b0;
    end
  endtask

  task automatic window(input int len_ns);
    meas_en = 1'b1;
    #(len_ns);
    meas_en = 1'b0;
    #300;
  endtask

  initial begin : wdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (20) @(negedge scan_clk);
    rst = 1'b0;
    @(negedge scan_clk);
    check("R10 sdo after reset", int'(sdo), 0, 0);

    // R10: counters cleared by reset, captured as zeros.
    capture(1'b0);
    read_all(1'b0);
    for (int i = 0; i < NOSC; i++) check("R10 count after reset", words[i], 0, 0);

    // R1 R2 R7 R9: 3 us window, every slot matches its own period.
    window(3000);
    capture(1'b0);
    read_all(1'b1);
    for (int i = 0; i < NOSC; i++) begin
      check((i % 2 == 0) ? "R1 R2 R7 stressed slot" : "R1 R2 R7 reference slot",
            words[i], 3000 / period_of(i), 1);
      first_w[i] = words[i];
    end

    // R4: no new window, counts frozen.
    #500;
    capture(1'b0);
    read_all(1'b0);
    for (int i = 0; i < NOSC; i++) check("R4 counts frozen", words[i], first_w[i], 0);

    // R3 R5 R6: 7 us window, capture coinciding with shift.
    window(7000);
    capture(1'b1);
    read_all(1'b0);
    check("R5 saturated osc0", words[0], MAXC, 0);
    check("R6 capture wins over shift, osc0 MSB intact", words[0] >> (CW - 1), 1, 0);
    for (int i = 1; i < NOSC; i++) begin
      check("R3 second window replaces first", words[i], 7000 / period_of(i), 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule